// File: doc/BRIEF.md
# Stack Transfer Sequencer

This block carries 16-bit words between the processor core and a byte-wide memory by way of the stack. It keeps its own 16-bit stack pointer. A single strobe starts an operation: push a word, push an accumulator/flag pair, pop a word, pop an accumulator/flag pair, call, return, conditional return, or store the stack pointer to an absolute address. The block then issues one memory byte access per cycle in a fixed order and ends with a one-cycle completion pulse.

The memory port has a registered address, write data and write enable. Read data must come back in the same cycle as the address, so the registered address can act as the address register of a block RAM. A push moves the pointer down before each byte: the high byte goes to the higher address and is written first. A pop reads the low byte first and moves the pointer up after each byte. The pointer wraps modulo 2^16 in both directions. Instruction decoding and the register file belong to the caller. The caller supplies the word to push, the return address and the condition result, and takes the popped word or the call target from the result output.

Top module: `stk_seq`

## Requirements
- R1: A push (op 0) with stack pointer S writes din[15:8] to address S-1 and, in a later cycle, din[7:0] to address S-2. The stack pointer ends at S-2.
- R2: A pop (op 2) with stack pointer S reads address S as the low byte and address S+1 as the high byte. The word is presented on result, and the stack pointer ends at S+2.
- R3: A flag push (op 1) packs din[3:0] = {Z,N,H,C} into the low byte as Z at bit 7, N at bit 6, H at bit 5 and C at bit 4, with bits 3..0 zero. The high byte is din[15:8]. Address order is the same as R1.
- R4: A flag pop (op 3) behaves as R2, except that result[3:0] is forced to zero.
- R5: A call (op 4) pushes pc_in as in R1 and then loads result with din, the target.
- R6: A return (op 5) pops into result as in R2. A conditional return (op 6) does the same when cond_ok is 1 at the start. When cond_ok is 0 it writes no memory and leaves both the stack pointer and result unchanged.
- R7: A stack pointer store (op 7) writes sp[7:0] to address din and then sp[15:8] to address din+1 (mod 2^16), in consecutive cycles. The stack pointer is not changed.
- R8: Counting the cycle in which start is accepted as cycle 0, done is high in cycle N. N is 4 for push, flag push and return, 3 for pop and flag pop, 6 for call, 5 for store, and 5 or 2 for a conditional return that is taken or not taken.
- R9: done is high for exactly one cycle per operation. A start that arrives while an operation is running is ignored.
- R10: The stack pointer wraps modulo 2^16 on decrement and on increment, and it moves by at most one per cycle.
- R11: After reset the stack pointer equals SP_RESET (default 0x0000), result is 0, and done and mem_we are 0. A memory write occurs only while an operation runs or in its done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op | input | 3 | Operation code, see R1 to R7 |
| din | input | 16 | Word to push, flag pair, call target or store address |
| pc_in | input | 16 | Return address pushed by a call |
| cond_ok | input | 1 | Condition result for the conditional return |
| mem_addr | output | 16 | Registered memory byte address |
| mem_wdata | output | 8 | Registered memory write byte |
| mem_we | output | 1 | Registered memory write enable |
| mem_rdata | input | 8 | Read byte for mem_addr, valid in the same cycle |
| result | output | 16 | Popped word or call target |
| sp | output | 16 | Current stack pointer |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench starts the pointer at zero so that the very first push wraps to 0xFFFF. The pop that follows then wraps back to 0x0000. A design that uses a wider or saturating pointer would leave the bytes at the wrong addresses. A store to 0xFFFF checks that the second byte wraps to address 0. Flag pushes and pops with non-zero low nibbles catch a packing that is off by a nibble, and a missing mask on the popped low bits. Starts are injected while an operation runs, with every input disturbed, to catch a design that restarts or that reads its operands after acceptance. Every operation's done cycle is counted against its exact length, and an untaken conditional return is checked for silence on the memory port.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

  localparam int STEP_W = 3;

  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_PUSHF = 3'd1,
    OP_POP   = 3'd2,
    OP_POPF  = 3'd3,
    OP_CALL  = 3'd4,
    OP_RET   = 3'd5,
    OP_RETC  = 3'd6,
    OP_STSP  = 3'd7
  } stk_op_e;

  typedef enum logic [3:0] {
    UA_NONE,
    UA_DEC,
    UA_WR_HI,
    UA_WR_LO,
    UA_RD_LO,
    UA_RD_HI,
    UA_TAKE,
    UA_ABS_LO,
    UA_ABS_HI,
    UA_LOAD
  } uact_e;

  // total cycles from acceptance to the done cycle
  function automatic logic [STEP_W-1:0] op_len(stk_op_e op, logic taken);
    logic [STEP_W-1:0] n;
    case (op)
      OP_PUSH, OP_PUSHF, OP_RET: n = 3'd4;
      OP_POP, OP_POPF:           n = 3'd3;
      OP_CALL:                   n = 3'd6;
      OP_RETC:                   n = taken ? 3'd5 : 3'd2;
      default:                   n = 3'd5;
    endcase
    return n;
  endfunction

  // micro action issued at the clock edge that ends step k
  function automatic uact_e uact(stk_op_e op, logic [STEP_W-1:0] k, logic taken);
    uact_e a;
    a = UA_NONE;
    case (op)
      OP_PUSH, OP_PUSHF, OP_CALL: begin
        case (k)
          3'd0:    a = UA_DEC;
          3'd1:    a = UA_WR_HI;
          3'd2:    a = UA_DEC;
          3'd3:    a = UA_WR_LO;
          3'd5:    a = (op == OP_CALL) ? UA_LOAD : UA_NONE;
          default: a = UA_NONE;
        endcase
      end
      OP_POP, OP_POPF, OP_RET: begin
        case (k)
          3'd0:    a = UA_RD_LO;
          3'd1:    a = UA_RD_HI;
          3'd2:    a = UA_TAKE;
          default: a = UA_NONE;
        endcase
      end
      OP_RETC: begin
        if (taken) begin
          case (k)
            3'd1:    a = UA_RD_LO;
            3'd2:    a = UA_RD_HI;
            3'd3:    a = UA_TAKE;
            default: a = UA_NONE;
          endcase
        end
      end
      default: begin
        case (k)
          3'd1:    a = UA_ABS_LO;
          3'd2:    a = UA_ABS_HI;
          default: a = UA_NONE;
        endcase
      end
    endcase
    return a;
  endfunction

endpackage

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
  import stk_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [2:0]  op,
  input  logic        cond_ok,
  output logic        accept,
  output uact_e       act,
  output logic        busy,
  output logic        done,
  output logic [2:0]  op_cur
);

  stk_op_e           op_q;
  logic              taken_q;
  logic [STEP_W-1:0] step_q;
  logic              last;

  assign accept = start && !busy;
  assign op_cur = op_q;
  assign last   = busy && (step_q == op_len(op_q, taken_q) - 3'd1);

  always_comb begin
    if (accept)    act = uact(stk_op_e'(op), '0, cond_ok);
    else if (busy) act = uact(op_q, step_q, taken_q);
    else           act = UA_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      step_q  <= '0;
      op_q    <= OP_PUSH;
      taken_q <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        busy    <= 1'b1;
        step_q  <= 3'd1;
        op_q    <= stk_op_e'(op);
        taken_q <= cond_ok;
      end else if (busy) begin
        step_q <= step_q + 3'd1;
        if (last) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/stk_seq_dp.sv
module stk_seq_dp
  import stk_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int FLAG_N = 4,
  parameter logic [2*BYTE_W-1:0] SP_RESET = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accept,
  input  logic [2:0]          op,
  input  logic [2*BYTE_W-1:0] din,
  input  logic [2*BYTE_W-1:0] pc_in,
  input  uact_e               act,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic [2*BYTE_W-1:0] mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic [2*BYTE_W-1:0] result,
  output logic [2*BYTE_W-1:0] sp
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam int PAD_W  = BYTE_W - FLAG_N;
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  logic [WORD_W-1:0] push_word;
  logic [WORD_W-1:0] wdat_q;
  logic [WORD_W-1:0] tgt_q;
  logic [BYTE_W-1:0] lo_q;
  logic [BYTE_W-1:0] lo_sel;
  logic              popf_q;

  // word written by push-type operations, flags packed into the top bits
  always_comb begin
    case (stk_op_e'(op))
      OP_CALL:  push_word = pc_in;
      OP_PUSHF: push_word = {din[WORD_W-1:BYTE_W], din[FLAG_N-1:0], {PAD_W{1'b0}}};
      default:  push_word = din;
    endcase
  end

  assign lo_sel = popf_q ? {lo_q[BYTE_W-1:PAD_W], {PAD_W{1'b0}}} : lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp        <= SP_RESET;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      result    <= '0;
      wdat_q    <= '0;
      tgt_q     <= '0;
      lo_q      <= '0;
      popf_q    <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (accept) begin
        wdat_q <= push_word;
        tgt_q  <= din;
        popf_q <= (stk_op_e'(op) == OP_POPF);
      end
      case (act)
        UA_DEC: sp <= sp - ONE;
        UA_WR_HI: begin
          mem_addr  <= sp;
          mem_wdata <= wdat_q[WORD_W-1:BYTE_W];
          mem_we    <= 1'b1;
        end
        UA_WR_LO: begin
          mem_addr  <= sp;
          mem_wdata <= wdat_q[BYTE_W-1:0];
          mem_we    <= 1'b1;
        end
        UA_RD_LO: begin
          mem_addr <= sp;
          sp       <= sp + ONE;
        end
        UA_RD_HI: begin
          lo_q     <= mem_rdata;
          mem_addr <= sp;
          sp       <= sp + ONE;
        end
        UA_TAKE: result <= {mem_rdata, lo_sel};
        UA_ABS_LO: begin
          mem_addr  <= tgt_q;
          mem_wdata <= sp[BYTE_W-1:0];
          mem_we    <= 1'b1;
        end
        UA_ABS_HI: begin
          mem_addr  <= tgt_q + ONE;
          mem_wdata <= sp[WORD_W-1:BYTE_W];
          mem_we    <= 1'b1;
        end
        UA_LOAD: result <= tgt_q;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int FLAG_N = 4,
  parameter logic [2*BYTE_W-1:0] SP_RESET = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [2:0]          op,
  input  logic [2*BYTE_W-1:0] din,
  input  logic [2*BYTE_W-1:0] pc_in,
  input  logic                cond_ok,
  output logic [2*BYTE_W-1:0] mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata,
  output logic                mem_we,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic [2*BYTE_W-1:0] result,
  output logic [2*BYTE_W-1:0] sp,
  output logic                done
);

  logic       accept_w;
  logic       busy_w;
  uact_e      act_w;
  logic [2:0] opq_w;

  stk_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op      (op),
    .cond_ok (cond_ok),
    .accept  (accept_w),
    .act     (act_w),
    .busy    (busy_w),
    .done    (done),
    .op_cur  (opq_w)
  );

  stk_seq_dp #(
    .BYTE_W   (BYTE_W),
    .FLAG_N   (FLAG_N),
    .SP_RESET (SP_RESET)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept_w),
    .op        (op),
    .din       (din),
    .pc_in     (pc_in),
    .act       (act_w),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .result    (result),
    .sp        (sp)
  );

endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              done,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_addr,
  input logic [WORD_W-1:0] sp,
  input logic              busy,
  input logic [2:0]        op_q
);

  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> $stable(op_q));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  sp_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sp == $past(sp) || sp == $past(sp) + ONE || sp == $past(sp) - ONE));

  // R7
  write_ascend_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ONE));

  // R11
  write_window_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (busy || done));

endmodule

bind stk_seq stk_seq_chk #(.WORD_W(2*BYTE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .done     (done),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .sp       (sp),
  .busy     (busy_w),
  .op_q     (opq_w)
);

// File: tb/tb_stk_seq.sv
`timescale 1ns/1ps
module tb_stk_seq;

  localparam logic [2:0] K_PUSH = 3'd0, K_PUSHF = 3'd1, K_POP = 3'd2, K_POPF = 3'd3,
                         K_CALL = 3'd4, K_RET = 3'd5, K_RETC = 3'd6, K_STSP = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [15:0] din = '0;
  logic [15:0] pc_in = '0;
  logic        cond_ok = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] result;
  logic [15:0] sp;
  logic        done;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  bmem [logic [15:0]];
  logic [7:0]  em   [logic [15:0]];
  logic [15:0] wl_a [8];
  logic [7:0]  wl_d [8];
  int          wl_n = 0;
  logic [15:0] esp = 16'h0000;
  logic [15:0] eres = 16'h0000;

  always #4 clk = ~clk;

  stk_seq dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .din(din), .pc_in(pc_in),
    .cond_ok(cond_ok), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .result(result), .sp(sp), .done(done)
  );

  // memory model: write in the write cycle, read data follows the address
  always @(negedge clk) begin
    if (mem_we) begin
      bmem[mem_addr] = mem_wdata;
      if (wl_n < 8) begin
        wl_a[wl_n] = mem_addr;
        wl_d[wl_n] = mem_wdata;
      end
      wl_n = wl_n + 1;
    end
    mem_rdata = bmem.exists(mem_addr) ? bmem[mem_addr] : 8'h00;
  end

  function automatic logic [7:0] emr(logic [15:0] a);
    return em.exists(a) ? em[a] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic run_op(input logic [2:0] o, input logic [15:0] d, input logic [15:0] pc,
                        input bit c, input bit poke);
    int          elen;
    int          ex_n;
    logic [15:0] ex_a [2];
    logic [7:0]  ex_d [2];
    logic [15:0] w;
    logic [7:0]  lo;
    logic [7:0]  hi;
    int          cyc;
    ex_n = 0;
    case (o)
      K_PUSH, K_PUSHF, K_CALL: begin
        w = (o == K_CALL) ? pc : (o == K_PUSHF) ? {d[15:8], d[3:0], 4'h0} : d;
        ex_a[0] = esp - 16'd1; ex_d[0] = w[15:8];
        ex_a[1] = esp - 16'd2; ex_d[1] = w[7:0];
        ex_n = 2;
        esp = esp - 16'd2;
        if (o == K_CALL) eres = d;
        elen = (o == K_CALL) ? 6 : 4;
      end
      K_STSP: begin
        ex_a[0] = d;          ex_d[0] = esp[7:0];
        ex_a[1] = d + 16'd1;  ex_d[1] = esp[15:8];
        ex_n = 2;
        elen = 5;
      end
      default: begin
        if (o == K_RETC && !c) begin
          elen = 2;
        end else begin
          lo = emr(esp);
          hi = emr(esp + 16'd1);
          if (o == K_POPF) lo = {lo[7:4], 4'h0};
          eres = {hi, lo};
          esp = esp + 16'd2;
          elen = (o == K_RET) ? 4 : (o == K_RETC) ? 5 : 3;
        end
      end
    endcase
    for (int i = 0; i < ex_n; i++) em[ex_a[i]] = ex_d[i];

    tick();
    op = o; din = d; pc_in = pc; cond_ok = c; start = 1'b1; wl_n = 0;
    tick();
    start = 1'b0;
    cyc = 1;
    if (poke) begin
      start = 1'b1; op = ~o; din = ~d; pc_in = ~pc; cond_ok = ~c;
    end
    while (!done && cyc < 40) begin
      tick();
      start = 1'b0;
      cyc++;
    end
    // R8 cycle count
    chk(cyc == elen, $sformatf("R8 op%0d length", o), cyc, elen);
    tick();
    // R9 single-cycle done
    chk(done == 1'b0, "R9 done width", done, 0);
    chk(sp == esp, $sformatf("R10 R1 R2 sp after op%0d", o), sp, esp);
    chk(result == eres, $sformatf("R2 R4 R5 R6 result after op%0d", o), result, eres);
    chk(wl_n == ex_n, $sformatf("R6 R7 write count op%0d", o), wl_n, ex_n);
    for (int i = 0; i < ex_n && i < wl_n; i++) begin
      chk(wl_a[i] == ex_a[i] && wl_d[i] == ex_d[i],
          $sformatf("R1 R3 R7 write %0d of op%0d", i, o),
          {wl_a[i], 8'h00, wl_d[i]}, {ex_a[i], 8'h00, ex_d[i]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7719));
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R11 reset state
    chk(sp == 16'h0000, "R11 reset sp", sp, 16'h0000);
    chk(result == 16'h0000, "R11 reset result", result, 0);
    chk(done == 1'b0 && mem_we == 1'b0, "R11 reset done/we", {done, mem_we}, 0);

    // R1 R10 push across the zero boundary, R2 pop back across it
    run_op(K_PUSH, 16'h1234, 16'h0, 1'b0, 1'b0);
    run_op(K_POP, 16'h0, 16'h0, 1'b0, 1'b0);
    // R3 flag packing, then R4 flag pop masks low nibble
    run_op(K_PUSHF, 16'hA50A, 16'h0, 1'b0, 1'b0);
    run_op(K_POP, 16'h0, 16'h0, 1'b0, 1'b0);
    run_op(K_PUSH, 16'h5A5F, 16'h0, 1'b0, 1'b0);
    run_op(K_POPF, 16'h0, 16'h0, 1'b0, 1'b0);
    // R5 call and R6 return
    run_op(K_CALL, 16'h8000, 16'h0203, 1'b0, 1'b0);
    run_op(K_RET, 16'h0, 16'h0, 1'b0, 1'b0);
    // R6 conditional return both ways
    run_op(K_CALL, 16'h4000, 16'hBEEF, 1'b0, 1'b0);
    run_op(K_RETC, 16'h0, 16'h0, 1'b0, 1'b0);
    run_op(K_RETC, 16'h0, 16'h0, 1'b1, 1'b0);
    // R7 store with address wrap
    run_op(K_STSP, 16'hFFFF, 16'h0, 1'b0, 1'b0);
    // R9 starts while busy are ignored
    run_op(K_PUSH, 16'hC3C3, 16'h0, 1'b0, 1'b1);
    run_op(K_RETC, 16'h0, 16'h0, 1'b0, 1'b1);
    run_op(K_POP, 16'h0, 16'h0, 1'b0, 1'b1);

    for (int n = 0; n < 400; n++) begin
      run_op(3'($urandom_range(0, 7)), 16'($urandom), 16'($urandom),
             1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule